// File: doc/BRIEF.md
# Row-Buffered Write Commit Controller

This block sits behind a two-wire serial slave front end. It gathers the data bytes of a single-byte or multi-byte write into a 16-entry row buffer and decides, at the end of the transfer, whether those bytes go into a 2048 x 8 storage array. If they do, it runs a timed programming cycle. During that cycle it streams the loaded bytes to the array and holds a busy flag that tells the front end to stay off the bus.

The front end reports a bus Start, the 11-bit target address, each received data byte, and a Stop. For the Stop it also says whether it arrived in the slot right after an acknowledge. It also passes the state of the write-inhibit pin. The upper seven address bits pick a row. Only the low four bits advance after each byte, so a long burst wraps back to the start of its row and overwrites earlier bytes. A per-offset valid mask makes sure that only the offsets actually sent are programmed.

Top module: `page_commit_ctrl`

## Requirements
- R1: On `addr_load` after a Start, `addr_in[10:4]` selects the row and `addr_in[3:0]` gives the first byte offset. Every array write of that transfer carries `mem_addr[10:4]` equal to that row.
- R2: Each `data_strobe` after the address stores `data_in` at the current offset. The offset then advances modulo 16, so it wraps inside the row. A later byte at the same offset replaces the earlier one.
- R3: If `inhibit` is high at the Start or at any cycle up to and including `addr_load`, the transfer stores no byte. Its Stop starts no cycle and causes no array write.
- R4: A cycle starts only on `stop_evt` with `stop_after_ack` high, after an address and at least one stored byte. Any other Stop starts nothing and empties the buffer.
- R5: A Start while idle empties the buffer and cancels the address. A Stop that follows without a new address and byte starts no cycle.
- R6: `busy` rises in the cycle after a committing Stop and stays high for exactly `WR_CYCLES` clock cycles.
- R7: During the first 16 busy cycles, offset k is presented in busy cycle k. `mem_we` is high only for loaded offsets, so loaded bytes reach the array in ascending offset order, one per clock. `mem_we` is never high outside busy.
- R8: While `busy` is high, Start, Stop, address and data inputs have no effect. They do not start a second cycle and do not alter the committed bytes.
- R9: After reset, `busy` and `mem_we` are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | One-cycle pulse: bus Start seen |
| stop_evt | input | 1 | One-cycle pulse: bus Stop seen |
| stop_after_ack | input | 1 | Qualifies `stop_evt`: Stop arrived in the slot right after an acknowledge |
| addr_load | input | 1 | One-cycle pulse: full address assembled |
| addr_in | input | 11 | Target address, valid with `addr_load` |
| data_strobe | input | 1 | One-cycle pulse: a data byte received |
| data_in | input | 8 | Received data byte, valid with `data_strobe` |
| inhibit | input | 1 | Write-inhibit pin level |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
A wrong offset register or valid mask shows up within the first 16 busy cycles. It appears either as an array write at the wrong address, a missing write, or an extra write to an offset that was never sent. A comparison of the array image after busy drops catches all three. A wrong decision in the intake state shows at `busy` one cycle after the Stop: a cycle that should not start, or one that should and does not. A miscounted timer shows as a busy pulse of the wrong length, and the bench measures that length in cycles.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;

    localparam int ADDR_W     = 11;
    localparam int DATA_W     = 8;
    localparam int OFF_W      = 4;
    localparam int WR_CYCLES  = 40;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_DATA  = 2'd2
    } intake_ph_e;

endpackage

// File: rtl/page_row_buf.sv
module page_row_buf #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int DEPTH = 1 << OFF_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0]             valid;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.valid = '0;
        end else if (wr_en) begin
            st_d.data[wr_off]  = wr_data;
            st_d.valid[wr_off] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.data[rd_off];
    assign rd_valid  = st_q.valid[rd_off];
    assign any_valid = |st_q.valid;

    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_valid);

    a_r2_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (st_q.valid[$past(wr_off)] &&
                             st_q.data[$past(wr_off)] == $past(wr_data)));

endmodule

// File: rtl/page_commit_seq.sv
module page_commit_seq #(
    parameter int OFF_W     = 4,
    parameter int WR_CYCLES = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic             busy,
    output logic [OFF_W-1:0] slot,
    output logic             slot_active,
    output logic             done
);
    localparam int DEPTH = 1 << OFF_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (go) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
            end
        end else if (st_q.cnt == LAST) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy        = st_q.busy;
    assign slot        = st_q.cnt[OFF_W-1:0];
    assign slot_active = st_q.busy && (int'(st_q.cnt) < DEPTH);
    assign done        = st_q.busy && (st_q.cnt == LAST);

    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != LAST) |=> st_q.busy);

    a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !st_q.busy);

    a_r6_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> st_q.cnt == '0);

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import page_commit_pkg::*;
#(
    parameter int P_ADDR_W    = page_commit_pkg::ADDR_W,
    parameter int P_DATA_W    = page_commit_pkg::DATA_W,
    parameter int P_OFF_W     = page_commit_pkg::OFF_W,
    parameter int P_WR_CYCLES = page_commit_pkg::WR_CYCLES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_evt,
    input  logic                stop_evt,
    input  logic                stop_after_ack,
    input  logic                addr_load,
    input  logic [P_ADDR_W-1:0] addr_in,
    input  logic                data_strobe,
    input  logic [P_DATA_W-1:0] data_in,
    input  logic                inhibit,
    output logic                busy,
    output logic                mem_we,
    output logic [P_ADDR_W-1:0] mem_addr,
    output logic [P_DATA_W-1:0] mem_wdata
);
    localparam int ROW_W = P_ADDR_W - P_OFF_W;

    typedef struct packed {
        intake_ph_e         ph;
        logic               inh;
        logic [ROW_W-1:0]   row;
        logic [P_OFF_W-1:0] off;
    } intake_t;

    intake_t st_d, st_q;

    logic                buf_wr, buf_clr, go;
    logic                seq_done, slot_active, rd_valid, any_valid;
    logic [P_OFF_W-1:0]  slot;
    logic [P_DATA_W-1:0] rd_data;

    always_comb begin
        st_d    = st_q;
        buf_wr  = 1'b0;
        buf_clr = seq_done;
        go      = 1'b0;
        if (!busy) begin
            if (start_evt) begin
                st_d.ph  = PH_SETUP;
                st_d.inh = inhibit;
                buf_clr  = 1'b1;
            end else if (stop_evt) begin
                if (stop_after_ack && st_q.ph == PH_DATA && !st_q.inh && any_valid)
                    go = 1'b1;
                else
                    buf_clr = 1'b1;
                st_d.ph  = PH_IDLE;
                st_d.inh = 1'b0;
            end else if (st_q.ph == PH_SETUP) begin
                if (inhibit) st_d.inh = 1'b1;
                if (addr_load) begin
                    st_d.ph  = PH_DATA;
                    st_d.row = addr_in[P_ADDR_W-1:P_OFF_W];
                    st_d.off = addr_in[P_OFF_W-1:0];
                end
            end else if (st_q.ph == PH_DATA && data_strobe) begin
                buf_wr   = !st_q.inh;
                st_d.off = st_q.off + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, inh: 1'b0, row: '0, off: '0};
        else        st_q <= st_d;
    end

    page_row_buf #(
        .DATA_W (P_DATA_W),
        .OFF_W  (P_OFF_W)
    ) i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr_en     (buf_wr),
        .wr_off    (st_q.off),
        .wr_data   (data_in),
        .rd_off    (slot),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    page_commit_seq #(
        .OFF_W     (P_OFF_W),
        .WR_CYCLES (P_WR_CYCLES)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .busy        (busy),
        .slot        (slot),
        .slot_active (slot_active),
        .done        (seq_done)
    );

    assign mem_we    = slot_active && rd_valid;
    assign mem_addr  = {st_q.row, slot};
    assign mem_wdata = rd_data;

    a_r7_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r4_bad_slot_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && !stop_after_ack) |=> !busy);

    a_r3_inhibited_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && st_q.inh) |=> !busy);

    a_r8_row_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.row));

    a_r5_start_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_evt) |=> st_q.ph == PH_SETUP);

endmodule

// File: tb/test_page_commit_ctrl.sv
module test_page_commit_ctrl;
    localparam int WR = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_evt = 0, stop_evt = 0, stop_after_ack = 0;
    logic        addr_load = 0, data_strobe = 0, inhibit = 0;
    logic [10:0] addr_in = '0;
    logic [7:0]  data_in = '0;
    logic        busy, mem_we;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;

    int checks = 0, fails = 0;
    logic [7:0] model [0:2047];
    int wlog [0:31];
    int wcount = 0;

    always #2.5 clk = ~clk;

    page_commit_ctrl #(.P_WR_CYCLES(WR)) i_page_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .stop_after_ack(stop_after_ack), .addr_load(addr_load), .addr_in(addr_in),
        .data_strobe(data_strobe), .data_in(data_in), .inhibit(inhibit),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) model[i] <= 8'h00;
        end else if (mem_we) begin
            model[mem_addr]   <= mem_wdata;
            wlog[wcount % 32] <= int'(mem_addr);
            wcount            <= wcount + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_evt = 1; @(negedge clk); start_evt = 0;
    endtask

    task automatic load_addr(input logic [10:0] a);
        addr_in = a; addr_load = 1; @(negedge clk); addr_load = 0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        data_in = d; data_strobe = 1; @(negedge clk); data_strobe = 0;
    endtask

    task automatic do_stop(input bit ack);
        stop_after_ack = ack; stop_evt = 1; @(negedge clk);
        stop_evt = 0; stop_after_ack = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset();
        chk(busy == 0, "R9 busy after reset", int'(busy), 0);
        chk(mem_we == 0, "R9 mem_we after reset", int'(mem_we), 0);
        do_stop(1);
        chk(busy == 0, "R9 empty buffer no commit", int'(busy), 0);
    endtask

    task automatic t_byte_write();
        int n, base;
        base = wcount;
        pulse_start(); load_addr(11'h123); send_byte(8'hA5); do_stop(1);
        chk(busy == 1, "R6 busy rises after stop", int'(busy), 1);
        wait_idle(n);
        chk(n == WR, "R6 busy length", n, WR);
        chk(model[11'h123] == 8'hA5, "R1 byte at address", int'(model[11'h123]), 'hA5);
        chk(wcount - base == 1, "R7 one write only", wcount - base, 1);
    endtask

    task automatic t_wrap();
        int n, base;
        base = wcount;
        pulse_start(); load_addr(11'h45E);
        send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
        do_stop(1); wait_idle(n);
        chk(model[11'h45E] == 8'hA0, "R2 offset E", int'(model[11'h45E]), 'hA0);
        chk(model[11'h45F] == 8'hA1, "R2 offset F", int'(model[11'h45F]), 'hA1);
        chk(model[11'h450] == 8'hA2, "R2 wrap to row start", int'(model[11'h450]), 'hA2);
        chk(model[11'h451] == 8'hA3, "R2 wrap offset 1", int'(model[11'h451]), 'hA3);
        chk(model[11'h460] == 8'h00, "R1 next row untouched", int'(model[11'h460]), 0);
        chk(wcount - base == 4, "R7 write count", wcount - base, 4);
        chk(wlog[(base+0)%32] == 'h450, "R7 order 0", wlog[(base+0)%32], 'h450);
        chk(wlog[(base+1)%32] == 'h451, "R7 order 1", wlog[(base+1)%32], 'h451);
        chk(wlog[(base+2)%32] == 'h45E, "R7 order 2", wlog[(base+2)%32], 'h45E);
        chk(wlog[(base+3)%32] == 'h45F, "R7 order 3", wlog[(base+3)%32], 'h45F);
    endtask

    task automatic t_rollover();
        int n, base;
        base = wcount;
        pulse_start(); load_addr(11'h200);
        for (int i = 0; i < 18; i++) send_byte(8'(8'h10 + i));
        do_stop(1); wait_idle(n);
        chk(model[11'h200] == 8'h20, "R2 overwrite offset 0", int'(model[11'h200]), 'h20);
        chk(model[11'h201] == 8'h21, "R2 overwrite offset 1", int'(model[11'h201]), 'h21);
        chk(model[11'h20F] == 8'h1F, "R2 offset F", int'(model[11'h20F]), 'h1F);
        chk(wcount - base == 16, "R7 sixteen writes", wcount - base, 16);
    endtask

    task automatic t_inhibit();
        int base;
        base = wcount;
        pulse_start(); inhibit = 1; @(negedge clk); inhibit = 0;
        load_addr(11'h300); send_byte(8'h77); do_stop(1);
        chk(busy == 0, "R3 no cycle when inhibited", int'(busy), 0);
        repeat (20) @(negedge clk);
        chk(model[11'h300] == 8'h00, "R3 location kept", int'(model[11'h300]), 0);
        chk(wcount == base, "R3 no array write", wcount - base, 0);
    endtask

    task automatic t_bad_stop();
        int base;
        base = wcount;
        pulse_start(); load_addr(11'h310); send_byte(8'h55); do_stop(0);
        chk(busy == 0, "R4 stop outside slot", int'(busy), 0);
        do_stop(1);
        chk(busy == 0, "R4 buffer discarded", int'(busy), 0);
        pulse_start(); load_addr(11'h311); do_stop(1);
        chk(busy == 0, "R4 address only no cycle", int'(busy), 0);
        repeat (20) @(negedge clk);
        chk(wcount == base, "R4 no writes", wcount - base, 0);
    endtask

    task automatic t_restart();
        int base;
        base = wcount;
        pulse_start(); load_addr(11'h320); send_byte(8'h66);
        pulse_start(); do_stop(1);
        chk(busy == 0, "R5 start cancels", int'(busy), 0);
        repeat (20) @(negedge clk);
        chk(model[11'h320] == 8'h00, "R5 location kept", int'(model[11'h320]), 0);
        chk(wcount == base, "R5 no writes", wcount - base, 0);
    endtask

    task automatic t_ignore_busy();
        int n, base;
        base = wcount;
        pulse_start(); load_addr(11'h050); send_byte(8'h11); do_stop(1);
        pulse_start(); load_addr(11'h060); send_byte(8'h22); do_stop(1);
        send_byte(8'h33);
        wait_idle(n);
        chk(n == WR - 5, "R8 busy not extended", n, WR - 5);
        repeat (5) @(negedge clk);
        chk(busy == 0, "R8 no second cycle", int'(busy), 0);
        do_stop(1);
        chk(busy == 0, "R8 nothing armed after busy", int'(busy), 0);
        chk(model[11'h050] == 8'h11, "R8 committed byte", int'(model[11'h050]), 'h11);
        chk(model[11'h060] == 8'h00, "R8 ignored write", int'(model[11'h060]), 0);
        chk(wcount - base == 1, "R8 single write", wcount - base, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_byte_write();
        t_wrap();
        t_rollover();
        t_inhibit();
        t_bad_stop();
        t_restart();
        t_ignore_busy();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule